// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block paces refresh for a DDR2-style memory controller. A free-running interval timer produces one refresh obligation per average refresh interval. The length of that interval depends on a temperature-grade input: about 7.8 us for the normal grade and about 3.9 us for the extended grade. Obligations collect in a debt counter, so the controller can defer refreshes while it has traffic to serve. Each REFRESH the controller issues pays back one unit of debt. The debt has a hard ceiling, which is the number of intervals that fit in the 70.3 us longest allowed gap between REFRESH commands. An urgent level rises one unit below that ceiling, so the controller stops deferring before the gap can be broken.

After each accepted REFRESH a blackout window of tRFC (127.5 ns) holds a busy flag high. During that window the controller must issue no ACTIVATE and no further REFRESH. A grant that arrives inside the window is not counted and is reported on an error output. Every time value is turned into controller clocks by rounding up against the clock-period parameter. The asynchronous reset is released through a two-stage synchronizer.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, and for two clocks after it is released, all outputs are low and the debt is zero.
- R2: With the grade input low, the interval is ceil(7800 ns / clock period) clocks, which is 390 at 20000 ps. Each interval end adds one unit of debt. The first request appears 392 clocks after reset release: 2 clocks of reset synchronization plus 390.
- R3: With the grade input high, the interval is ceil(3900 ns / clock period) clocks, which is 195 at 20000 ps.
- R4: The request output is high exactly when the debt is nonzero, the idle input is high and busy is low.
- R5: A grant sampled while busy is low is accepted. It lowers the debt by one, but never below zero. If an interval end and an accepted grant fall on the same clock, the debt is unchanged.
- R6: Busy rises on the clock after an accepted grant and stays high for ceil(127.5 ns / clock period) clocks, which is 7 at 20000 ps.
- R7: A grant sampled while busy is high raises the error output for exactly the next clock. It leaves the debt unchanged and does not restart the busy window.
- R8: The urgent output is high whenever the debt is at least the ceiling minus one. That is 8 with the grade input low and 17 with it high. The idle and busy inputs do not affect it.
- R9: The debt saturates at its ceiling: 9 with the grade input low, 18 with it high. An interval end that finds the debt at the ceiling adds nothing.
- R10: A change of grade does not clear the interval timer. If the count already elapsed is at least the new interval minus one, the interval ends on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ind_grade_i | input | 1 | 1 selects the extended temperature grade (shorter interval) |
| ref_grant_i | input | 1 | High for one clock for each REFRESH command issued |
| bank_idle_i | input | 1 | All banks precharged, so a refresh may be issued now |
| ref_req_o | output | 1 | Refresh requested |
| ref_urgent_o | output | 1 | Debt near its ceiling; refresh must not be deferred |
| rfc_busy_o | output | 1 | tRFC blackout window active |
| grant_err_o | output | 1 | Previous-clock grant fell inside the blackout window |

## Verification
The assertions take all inputs as synchronous to the clock and settled before each rising edge. They treat a grant held for several clocks as one grant per sampled clock. The grade input may change at any clock, so the debt bound is checked against the larger of the two ceilings. The stimulus changes its inputs a short delay after each rising edge and samples results at the falling edge. Grants are issued both inside and outside the blackout window, and the grade is switched part-way through an interval.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Integer division rounded up, used for time-to-clock conversion.
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned LIM_COM = 390,
  parameter int unsigned LIM_IND = 195
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ind_i,
  output logic tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;

  // The timer keeps counting across a grade change; a compare with >= ends
  // an interval at once when the new limit is already passed.
  always_comb begin
    last_idx = ind_i ? CNT_W'(LIM_IND - 1) : CNT_W'(LIM_COM - 1);
    tick_o   = (cnt_q >= last_idx);
    cnt_d    = tick_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
  parameter int unsigned DEBT_W  = 5,
  parameter int unsigned CAP_COM = 9,
  parameter int unsigned CAP_IND = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ind_i,
  input  logic              tick_i,
  input  logic              pay_i,
  output logic [DEBT_W-1:0] debt_o,
  output logic              urgent_o
);

  localparam logic [DEBT_W-1:0] CapC = DEBT_W'(CAP_COM);
  localparam logic [DEBT_W-1:0] CapI = DEBT_W'(CAP_IND);

  logic [DEBT_W-1:0] debt_q, debt_d, cap;
  logic              inc, dec, debt_en;

  always_comb begin
    cap      = ind_i ? CapI : CapC;
    inc      = tick_i && (debt_q < cap);
    dec      = pay_i && (debt_q != '0);
    debt_en  = inc ^ dec;
    debt_d   = inc ? debt_q + DEBT_W'(1) : debt_q - DEBT_W'(1);
    urgent_o = (debt_q >= cap - DEBT_W'(1));
    debt_o   = debt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      debt_q <= '0;
    else if (debt_en) debt_q <= debt_d;
  end

endmodule

// File: rtl/rfsh_blackout.sv
module rfsh_blackout #(
  parameter int unsigned RFC_CYC = 7,
  parameter int unsigned WIN_W   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic accept_o,
  output logic busy_o,
  output logic err_o
);

  logic [WIN_W-1:0] win_q, win_d;
  logic             win_en, err_q, err_d;

  always_comb begin
    busy_o   = (win_q != '0);
    accept_o = grant_i && !busy_o;
    err_d    = grant_i && busy_o;
    win_en   = accept_o || busy_o;
    win_d    = accept_o ? WIN_W'(RFC_CYC) : win_q - WIN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (win_en) win_q <= win_d;
      err_q <= err_d;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_PS      = 20000,
  parameter int unsigned REFI_COM_NS = 7800,
  parameter int unsigned REFI_IND_NS = 3900,
  parameter int unsigned RFC_PS      = 127500,
  parameter int unsigned MAX_GAP_NS  = 70300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ind_grade_i,
  input  logic ref_grant_i,
  input  logic bank_idle_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic rfc_busy_o,
  output logic grant_err_o
);

  localparam int unsigned LIM_COM = ceil_div(REFI_COM_NS * 1000, CLK_PS);
  localparam int unsigned LIM_IND = ceil_div(REFI_IND_NS * 1000, CLK_PS);
  localparam int unsigned RFC_CYC = ceil_div(RFC_PS, CLK_PS);
  localparam int unsigned CAP_COM = MAX_GAP_NS / REFI_COM_NS;
  localparam int unsigned CAP_IND = MAX_GAP_NS / REFI_IND_NS;
  localparam int unsigned CNT_W   = $clog2(max2(LIM_COM, LIM_IND) + 1);
  localparam int unsigned DEBT_W  = $clog2(max2(CAP_COM, CAP_IND) + 1);
  localparam int unsigned WIN_W   = $clog2(RFC_CYC + 1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              tick;
  logic              grant_ok;
  logic [DEBT_W-1:0] debt;

  rfsh_interval_timer #(
    .CNT_W  (CNT_W),
    .LIM_COM(LIM_COM),
    .LIM_IND(LIM_IND)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .ind_i (ind_grade_i),
    .tick_o(tick)
  );

  rfsh_debt_ctr #(
    .DEBT_W (DEBT_W),
    .CAP_COM(CAP_COM),
    .CAP_IND(CAP_IND)
  ) u_debt (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .ind_i   (ind_grade_i),
    .tick_i  (tick),
    .pay_i   (grant_ok),
    .debt_o  (debt),
    .urgent_o(ref_urgent_o)
  );

  rfsh_blackout #(
    .RFC_CYC(RFC_CYC),
    .WIN_W  (WIN_W)
  ) u_blackout (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .grant_i (ref_grant_i),
    .accept_o(grant_ok),
    .busy_o  (rfc_busy_o),
    .err_o   (grant_err_o)
  );

  assign ref_req_o = (debt != '0) && bank_idle_i && !rfc_busy_o;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int unsigned DEBT_W  = 5,
  parameter int unsigned CAP_COM = 9,
  parameter int unsigned CAP_IND = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ind,
  input logic              grant,
  input logic              idle,
  input logic              tick,
  input logic [DEBT_W-1:0] debt,
  input logic              req,
  input logic              urgent,
  input logic              busy,
  input logic              err
);

  logic [DEBT_W-1:0] cap_now;
  assign cap_now = ind ? DEBT_W'(CAP_IND) : DEBT_W'(CAP_COM);

  assert_tick_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(grant && !busy) && (debt < cap_now)) |=> (debt == DEBT_W'($past(debt) + 1'b1)));

  assert_req_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !idle) |-> !req);

  assert_busy_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !busy) |=> busy);

  assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && busy) |=> err);

  assert_err_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && busy && !tick) |=> $stable(debt));

  assert_urgent_has_debt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> (debt != '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DEBT_W'(CAP_IND));

endmodule

bind dram_refresh_sched rfsh_sched_chk #(
  .DEBT_W (DEBT_W),
  .CAP_COM(CAP_COM),
  .CAP_IND(CAP_IND)
) u_chk (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .ind   (ind_grade_i),
  .grant (ref_grant_i),
  .idle  (bank_idle_i),
  .tick  (tick),
  .debt  (debt),
  .req   (ref_req_o),
  .urgent(ref_urgent_o),
  .busy  (rfc_busy_o),
  .err   (grant_err_o)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;

  localparam int CLK_PS = 20000;
  localparam int T_COM  = (7800 * 1000 + CLK_PS - 1) / CLK_PS;  // 390
  localparam int T_IND  = (3900 * 1000 + CLK_PS - 1) / CLK_PS;  // 195
  localparam int T_RFC  = (127500 + CLK_PS - 1) / CLK_PS;       // 7
  localparam int C_COM  = 70300 / 7800;                         // 9
  localparam int C_IND  = 70300 / 3900;                         // 18

  logic clk = 1'b0;
  logic rst_n, grade, grant, idle;
  logic req, urgent, busy, err;

  always #10ns clk = ~clk;

  dram_refresh_sched u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ind_grade_i (grade),
    .ref_grant_i (grant),
    .bank_idle_i (idle),
    .ref_req_o   (req),
    .ref_urgent_o(urgent),
    .rfc_busy_o  (busy),
    .grant_err_o (err)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit chk_on = 0;
  bit done = 0;

  // Behavioural reference model
  bit s1, s2;
  int m_cnt, m_debt, m_busy;
  bit m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; m_cnt = 0; m_debt = 0; m_busy = 0; m_err = 0; cyc = 0;
    end else begin
      cyc = cyc + 1;
      if (!s2) begin
        m_cnt = 0; m_debt = 0; m_busy = 0; m_err = 0;
      end else begin
        int lim, cap, nd;
        bit tk, acc;
        lim = grade ? T_IND : T_COM;
        cap = grade ? C_IND : C_COM;
        tk = (m_cnt >= lim - 1);
        m_cnt = tk ? 0 : m_cnt + 1;
        acc = grant && (m_busy == 0);
        m_err = grant && (m_busy != 0);
        nd = m_debt;
        if (tk && m_debt < cap) nd = nd + 1;
        if (acc && m_debt > 0) nd = nd - 1;
        m_debt = nd;
        if (acc) m_busy = T_RFC;
        else if (m_busy > 0) m_busy = m_busy - 1;
      end
      s2 = s1; s1 = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R4 ref_req", int'(req), int'(m_debt > 0 && idle && m_busy == 0));
      chk("R8 urgent", int'(urgent), int'(m_debt >= (grade ? C_IND - 1 : C_COM - 1)));
      chk("R6 busy", int'(busy), int'(m_busy > 0));
      chk("R7 grant_err", int'(err), int'(m_err));
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    report();
  end

  task automatic pulse_grant();
    @(posedge clk); #2ns grant = 1'b1;
    @(posedge clk); #2ns grant = 1'b0;
  endtask

  task automatic wait_req_rise(output int at);
    @(negedge clk);
    while (!req) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    int t0, t1, n;
    rst_n = 1'b0; grade = 1'b0; grant = 1'b0; idle = 1'b1;
    repeat (3) @(posedge clk);
    #2ns rst_n = 1'b1;
    chk_on = 1;

    // R1: quiet after release
    @(negedge clk);
    chk("R1 req after reset", int'(req), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 urgent/err after reset", int'(urgent | err), 0);

    // R2: first request 2 + T_COM clocks after release
    wait_req_rise(t0);
    chk("R2 first request cycle", t0, 2 + T_COM);

    // R5/R6: accepted grant, busy window length
    pulse_grant();
    // R7: grant inside the window
    pulse_grant();
    @(negedge clk);
    chk("R7 err after busy grant", int'(err), 1);
    while (busy) @(negedge clk);
    pulse_grant();  // R5: debt already zero
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    chk("R6 busy length", n, T_RFC);
    chk("R5 no underflow", int'(req), 0);

    // R2: next interval end unaffected by grants
    wait_req_rise(t1);
    chk("R2 interval", t1 - t0, T_COM);
    pulse_grant();

    // R10: grade switch after count passed the new limit
    @(negedge clk);
    while (cyc != t1 + 250) @(negedge clk);
    @(posedge clk); #2ns grade = 1'b1;
    wait_req_rise(t0);
    chk("R10 early end on grade switch", t0 - t1, 252);
    pulse_grant();

    // R3: extended-grade interval
    wait_req_rise(t1);
    chk("R3 interval", t1 - t0, T_IND);
    pulse_grant();

    // R8: urgent with idle low
    @(posedge clk); #2ns grade = 1'b0; idle = 1'b0;
    @(negedge clk);
    while (!urgent) @(negedge clk);
    chk("R8 urgent cycle", cyc - t1, (C_COM - 1) * T_COM);
    chk("R4 no req when not idle", int'(req), 0);

    // R9: saturation; after 12 interval ends two grants drop below urgent
    while (cyc < t1 + 12 * T_COM + 1) @(negedge clk);
    pulse_grant();
    while (busy) @(negedge clk);
    pulse_grant();
    @(negedge clk);
    chk("R9 debt saturated", int'(urgent), 0);

    // Mixed stimulus checked against the model
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #2ns;
      grant = ($urandom % 6 == 0);
      idle  = ($urandom % 4 != 0);
      if ($urandom % 700 == 0) grade = ~grade;
    end
    @(posedge clk); #2ns grant = 1'b0;
    @(negedge clk);
    done = 1;
    report();
  end

endmodule